// File: doc/BRIEF.md
# Command Stream Decoder for a Data-Parallel Array

This block walks a command buffer held in memory and turns it into control for a data-parallel processor array. The host gives a start word address and a length in words and pulses `start`. The block then reads the buffer one word at a time. The first word of each command is an opcode, and the opcode fixes how many parameter words come after it. Once a command is complete, the block applies it. A command can update a configuration register, emit a one-cycle cache maintenance pulse, hand a launch request to the domain scheduler, hold decoding until the array is idle, or work on the two built-in cycle counters.

The state machine has these states:
- `ST_IDLE`: waiting for `start`.
- `ST_FETCH`: issues one read.
- `ST_WAIT`: waits for the read data.
- `ST_EXEC`: applies the completed command for one cycle.
- `ST_LAUNCH`: holds `launch_valid` until `launch_ready`.
- `ST_DRAIN`: waits until `array_busy` is low.
- `ST_DUMP_LO` and `ST_DUMP_HI`: write the counter snapshot.
- `ST_HALT`: error, left only by reset.

The transitions are:
- `ST_IDLE` goes to `ST_FETCH` on start with a non-zero length.
- `ST_FETCH` always goes to `ST_WAIT`.
- `ST_WAIT` goes to `ST_EXEC` when the command is complete, back to `ST_FETCH` when more parameters are due, or to `ST_HALT` on a bad opcode or a truncated command.
- `ST_EXEC` goes to `ST_LAUNCH`, `ST_DRAIN` or `ST_DUMP_LO` for the commands that need them. For any other command it goes to `ST_FETCH`, or to `ST_IDLE` when the buffer is exhausted.
- `ST_LAUNCH` and `ST_DRAIN` continue the same way once their condition holds.
- `ST_DUMP_LO` goes to `ST_DUMP_HI`, which then continues the same way.

The domain scheduler must raise `array_busy` no later than the cycle after it accepts a launch. This lets a barrier that follows a launch see the work that was started.

Top module: `cmdbuf_engine`

## Requirements
- R1: After reset every configuration output, `cache_op`, `launch_valid`, `rd_req`, `wr_en`, `busy`, `consumed` and `error` are zero.
- R2: Words are read from `buf_addr` upward, one request at a time. With a memory that returns data one cycle after the request, each word costs two cycles and each command one extra execute cycle. `consumed` rises once the last word has been read and stays high until the next `start`. A zero length sets `consumed` at once and reads nothing.
- R3: Opcodes (full 32-bit word) and parameter counts:
  - 0x01 input setup (index, address, format, components)
  - 0x02 output setup (same four parameters)
  - 0x03 constant address
  - 0x04 conditional-buffer address and format
  - 0x05 program address
  - 0x0B conditional test
  
  Each loads the matching output registers. Format keeps the low FMT_W bits, components the low COMP_W bits, and the test value the low TEST_W bits.
- R4: An input index of NUM_IN or more, or an output index of NUM_OUT or more, leaves every input and output register unchanged.
- R5: The parameterless cache opcodes each give a pulse of exactly one cycle on one bit of `cache_op`:
  - 0x06 on bit 0 (invalidate input)
  - 0x07 on bit 1 (invalidate constant)
  - 0x08 on bit 2 (invalidate conditional)
  - 0x09 on bit 3 (flush output)
  - 0x0A on bit 4 (flush conditional)
- R6: 0x0C takes x0, y0, x1 and y1 and sets the domain outputs. 0x0D raises `launch_valid` and holds it, issuing no read, until `launch_ready` is sampled high. The next cycle it is low.
- R7: 0x0E stops every later command from taking effect while `array_busy` is high.
- R8: The total counter increments every cycle, and the active counter increments every cycle with `array_busy` high. Opcode 0x0F clears both in its execute cycle.
- R9: 0x10 takes one address A. In two consecutive cycles it writes the total count to A and then the active count to A+1, both as they stood in its execute cycle.
- R10: Any other opcode sets `error`, which stays set until reset. Reading then stops, `busy` drops, and `start` is ignored.
- R11: A buffer that ends before a command's parameters are complete sets `error` the same way and does not apply that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a buffer (taken in idle only) |
| buf_addr | input | ADDR_W | First word address |
| buf_len | input | LEN_W | Buffer length in words |
| busy | output | 1 | Buffer being processed |
| consumed | output | 1 | Last word of the buffer read |
| error | output | 1 | Sticky decode error |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | ADDR_W | Read word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | ADDR_W | Write word address |
| wr_data | output | 32 | Write data |
| in_addr | output | NUM_IN x 32 | Input base addresses |
| in_fmt | output | NUM_IN x FMT_W | Input formats |
| in_comp | output | NUM_IN x COMP_W | Input component counts |
| out_addr | output | NUM_OUT x 32 | Output base addresses |
| out_fmt | output | NUM_OUT x FMT_W | Output formats |
| out_comp | output | NUM_OUT x COMP_W | Output component counts |
| const_addr | output | 32 | Constant base address |
| prog_addr | output | 32 | Program base address |
| cond_addr | output | 32 | Conditional buffer address |
| cond_fmt | output | FMT_W | Conditional buffer format |
| cond_test | output | TEST_W | Conditional comparison select |
| dom_x0 | output | COORD_W | Domain corner x0 |
| dom_y0 | output | COORD_W | Domain corner y0 |
| dom_x1 | output | COORD_W | Domain corner x1 |
| dom_y1 | output | COORD_W | Domain corner y1 |
| cache_op | output | 5 | Cache maintenance pulses |
| launch_valid | output | 1 | Launch request |
| launch_ready | input | 1 | Launch accepted |
| array_busy | input | 1 | Array not idle |

## Verification
The bench builds the block with NUM_IN=3 and NUM_OUT=2, leaving the other parameters at their defaults. With three inputs, the first illegal input index is 3. That value still fits in the two-bit index field, so an index check that only truncated bits would be caught. With two outputs, index 2 becomes the out-of-range case. The bench memory answers one cycle after each request, which fixes the counter values a dump should report.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_EXEC,
        ST_LAUNCH,
        ST_DRAIN,
        ST_DUMP_LO,
        ST_DUMP_HI,
        ST_HALT
    } cb_state_t;

    localparam logic [31:0] OP_SET_INPUT  = 32'h0000_0001;
    localparam logic [31:0] OP_SET_OUTPUT = 32'h0000_0002;
    localparam logic [31:0] OP_SET_CONST  = 32'h0000_0003;
    localparam logic [31:0] OP_SET_COND   = 32'h0000_0004;
    localparam logic [31:0] OP_SET_PROG   = 32'h0000_0005;
    localparam logic [31:0] OP_INV_INPUT  = 32'h0000_0006;
    localparam logic [31:0] OP_INV_CONST  = 32'h0000_0007;
    localparam logic [31:0] OP_INV_COND   = 32'h0000_0008;
    localparam logic [31:0] OP_FLUSH_OUT  = 32'h0000_0009;
    localparam logic [31:0] OP_FLUSH_COND = 32'h0000_000A;
    localparam logic [31:0] OP_SET_TEST   = 32'h0000_000B;
    localparam logic [31:0] OP_SET_DOMAIN = 32'h0000_000C;
    localparam logic [31:0] OP_LAUNCH     = 32'h0000_000D;
    localparam logic [31:0] OP_BARRIER    = 32'h0000_000E;
    localparam logic [31:0] OP_PERF_CLEAR = 32'h0000_000F;
    localparam logic [31:0] OP_PERF_DUMP  = 32'h0000_0010;

    localparam int CACHE_OPS     = 5;
    localparam int CB_INV_INPUT  = 0;
    localparam int CB_INV_CONST  = 1;
    localparam int CB_INV_COND   = 2;
    localparam int CB_FLUSH_OUT  = 3;
    localparam int CB_FLUSH_COND = 4;

    function automatic logic op_known(input logic [31:0] op);
        return (op >= OP_SET_INPUT) && (op <= OP_PERF_DUMP);
    endfunction

    function automatic logic [2:0] op_param_count(input logic [31:0] op);
        logic [2:0] n;
        case (op)
            OP_SET_INPUT, OP_SET_OUTPUT, OP_SET_DOMAIN: n = 3'd4;
            OP_SET_COND:                                n = 3'd2;
            OP_SET_CONST, OP_SET_PROG,
            OP_SET_TEST, OP_PERF_DUMP:                  n = 3'd1;
            default:                                    n = 3'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cmdbuf_walker.sv
module cmdbuf_walker #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output logic              last,
    output logic              done,
    output logic              consumed
);

    logic [ADDR_W-1:0] ptr_q;
    logic [LEN_W-1:0]  rem_q;
    logic              cons_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            rem_q  <= '0;
            cons_q <= 1'b0;
        end else if (load) begin
            ptr_q  <= load_addr;
            rem_q  <= load_len;
            cons_q <= (load_len == '0);
        end else if (step) begin
            ptr_q <= ptr_q + 1'b1;
            rem_q <= rem_q - 1'b1;
            if (rem_q == LEN_W'(1)) begin
                cons_q <= 1'b1;
            end
        end
    end

    assign ptr      = ptr_q;
    assign last     = (rem_q == LEN_W'(1));
    assign done     = (rem_q == '0);
    assign consumed = cons_q;

endmodule

// File: rtl/cmdbuf_perf.sv
module cmdbuf_perf #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic             snap,
    output logic [CNT_W-1:0] total_snap,
    output logic [CNT_W-1:0] active_snap
);

    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q  <= '0;
            active_q <= '0;
        end else if (clear) begin
            total_q  <= '0;
            active_q <= '0;
        end else begin
            total_q <= total_q + 1'b1;
            if (active) begin
                active_q <= active_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_snap  <= '0;
            active_snap <= '0;
        end else if (snap) begin
            total_snap  <= total_q;
            active_snap <= active_q;
        end
    end

endmodule

// File: rtl/cmdbuf_engine.sv
module cmdbuf_engine
    import cmdbuf_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 16,
    parameter int NUM_IN  = 4,
    parameter int NUM_OUT = 4,
    parameter int FMT_W   = 4,
    parameter int COMP_W  = 3,
    parameter int TEST_W  = 3,
    parameter int COORD_W = 16,
    parameter int CNT_W   = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [ADDR_W-1:0]              buf_addr,
    input  logic [LEN_W-1:0]               buf_len,
    output logic                           busy,
    output logic                           consumed,
    output logic                           error,
    output logic                           rd_req,
    output logic [ADDR_W-1:0]              rd_addr,
    input  logic                           rd_valid,
    input  logic [31:0]                    rd_data,
    output logic                           wr_en,
    output logic [ADDR_W-1:0]              wr_addr,
    output logic [31:0]                    wr_data,
    output logic [NUM_IN-1:0][31:0]        in_addr,
    output logic [NUM_IN-1:0][FMT_W-1:0]   in_fmt,
    output logic [NUM_IN-1:0][COMP_W-1:0]  in_comp,
    output logic [NUM_OUT-1:0][31:0]       out_addr,
    output logic [NUM_OUT-1:0][FMT_W-1:0]  out_fmt,
    output logic [NUM_OUT-1:0][COMP_W-1:0] out_comp,
    output logic [31:0]                    const_addr,
    output logic [31:0]                    prog_addr,
    output logic [31:0]                    cond_addr,
    output logic [FMT_W-1:0]               cond_fmt,
    output logic [TEST_W-1:0]              cond_test,
    output logic [COORD_W-1:0]             dom_x0,
    output logic [COORD_W-1:0]             dom_y0,
    output logic [COORD_W-1:0]             dom_x1,
    output logic [COORD_W-1:0]             dom_y1,
    output logic [CACHE_OPS-1:0]           cache_op,
    output logic                           launch_valid,
    input  logic                           launch_ready,
    input  logic                           array_busy
);

    localparam int MAX_PRM = 4;

    cb_state_t state, nstate;

    logic [31:0]              op_q;
    logic [MAX_PRM-1:0][31:0] prm_q;
    logic [2:0]               pidx_q;
    logic [2:0]               need_q;
    logic                     in_params_q;
    logic                     err_q;

    logic              walk_load, walk_step, walk_last, walk_done;
    logic [ADDR_W-1:0] walk_ptr;
    logic              perf_clear, perf_snap;
    logic [CNT_W-1:0]  total_snap, active_snap;
    logic              word_take;
    cb_state_t         cont_state;

    cmdbuf_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (walk_load),
        .load_addr (buf_addr),
        .load_len  (buf_len),
        .step      (walk_step),
        .ptr       (walk_ptr),
        .last      (walk_last),
        .done      (walk_done),
        .consumed  (consumed)
    );

    cmdbuf_perf #(.CNT_W(CNT_W)) u_perf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (perf_clear),
        .active      (array_busy),
        .snap        (perf_snap),
        .total_snap  (total_snap),
        .active_snap (active_snap)
    );

    assign word_take  = (state == ST_WAIT) && rd_valid;
    assign cont_state = walk_done ? ST_IDLE : ST_FETCH;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (start && (buf_len != '0)) nstate = ST_FETCH;
            end
            ST_FETCH: nstate = ST_WAIT;
            ST_WAIT: begin
                if (rd_valid) begin
                    if (!in_params_q) begin
                        if (!op_known(rd_data))                   nstate = ST_HALT;
                        else if (op_param_count(rd_data) == 3'd0) nstate = ST_EXEC;
                        else if (walk_last)                       nstate = ST_HALT;
                        else                                      nstate = ST_FETCH;
                    end else begin
                        if (3'(pidx_q + 3'd1) == need_q) nstate = ST_EXEC;
                        else if (walk_last)              nstate = ST_HALT;
                        else                             nstate = ST_FETCH;
                    end
                end
            end
            ST_EXEC: begin
                if (op_q == OP_LAUNCH)        nstate = ST_LAUNCH;
                else if (op_q == OP_BARRIER)  nstate = ST_DRAIN;
                else if (op_q == OP_PERF_DUMP) nstate = ST_DUMP_LO;
                else                          nstate = cont_state;
            end
            ST_LAUNCH:  if (launch_ready) nstate = cont_state;
            ST_DRAIN:   if (!array_busy)  nstate = cont_state;
            ST_DUMP_LO: nstate = ST_DUMP_HI;
            ST_DUMP_HI: nstate = cont_state;
            ST_HALT:    nstate = ST_HALT;
            default:    nstate = ST_IDLE;
        endcase
    end

    // command collection and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q        <= '0;
            prm_q       <= '0;
            pidx_q      <= '0;
            need_q      <= '0;
            in_params_q <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            if (nstate == ST_HALT && state != ST_HALT) begin
                err_q <= 1'b1;
            end
            if (state == ST_IDLE || state == ST_EXEC) begin
                in_params_q <= 1'b0;
            end else if (word_take) begin
                if (!in_params_q) begin
                    op_q        <= rd_data;
                    need_q      <= op_param_count(rd_data);
                    pidx_q      <= '0;
                    in_params_q <= (op_param_count(rd_data) != 3'd0);
                end else begin
                    prm_q[pidx_q[1:0]] <= rd_data;
                    pidx_q             <= pidx_q + 3'd1;
                end
            end
        end
    end

    // configuration registers, written in the execute cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_addr    <= '0;
            in_fmt     <= '0;
            in_comp    <= '0;
            out_addr   <= '0;
            out_fmt    <= '0;
            out_comp   <= '0;
            const_addr <= '0;
            prog_addr  <= '0;
            cond_addr  <= '0;
            cond_fmt   <= '0;
            cond_test  <= '0;
            dom_x0     <= '0;
            dom_y0     <= '0;
            dom_x1     <= '0;
            dom_y1     <= '0;
        end else if (state == ST_EXEC) begin
            case (op_q)
                OP_SET_INPUT: begin
                    for (int i = 0; i < NUM_IN; i++) begin
                        if (prm_q[0] == 32'(i)) begin
                            in_addr[i] <= prm_q[1];
                            in_fmt[i]  <= prm_q[2][FMT_W-1:0];
                            in_comp[i] <= prm_q[3][COMP_W-1:0];
                        end
                    end
                end
                OP_SET_OUTPUT: begin
                    for (int i = 0; i < NUM_OUT; i++) begin
                        if (prm_q[0] == 32'(i)) begin
                            out_addr[i] <= prm_q[1];
                            out_fmt[i]  <= prm_q[2][FMT_W-1:0];
                            out_comp[i] <= prm_q[3][COMP_W-1:0];
                        end
                    end
                end
                OP_SET_CONST: const_addr <= prm_q[0];
                OP_SET_PROG:  prog_addr  <= prm_q[0];
                OP_SET_COND: begin
                    cond_addr <= prm_q[0];
                    cond_fmt  <= prm_q[1][FMT_W-1:0];
                end
                OP_SET_TEST: cond_test <= prm_q[0][TEST_W-1:0];
                OP_SET_DOMAIN: begin
                    dom_x0 <= prm_q[0][COORD_W-1:0];
                    dom_y0 <= prm_q[1][COORD_W-1:0];
                    dom_x1 <= prm_q[2][COORD_W-1:0];
                    dom_y1 <= prm_q[3][COORD_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from the state register
    always_comb begin
        rd_req       = (state == ST_FETCH);
        rd_addr      = walk_ptr;
        walk_load    = (state == ST_IDLE) && start;
        walk_step    = word_take;
        launch_valid = (state == ST_LAUNCH);
        busy         = (state != ST_IDLE) && (state != ST_HALT);
        error        = err_q;
        wr_en        = (state == ST_DUMP_LO) || (state == ST_DUMP_HI);
        wr_addr      = prm_q[0][ADDR_W-1:0] + ((state == ST_DUMP_HI) ? ADDR_W'(1) : ADDR_W'(0));
        wr_data      = (state == ST_DUMP_HI) ? 32'(active_snap) : 32'(total_snap);
        perf_clear   = (state == ST_EXEC) && (op_q == OP_PERF_CLEAR);
        perf_snap    = (state == ST_EXEC) && (op_q == OP_PERF_DUMP);
        cache_op     = '0;
        if (state == ST_EXEC) begin
            cache_op[CB_INV_INPUT]  = (op_q == OP_INV_INPUT);
            cache_op[CB_INV_CONST]  = (op_q == OP_INV_CONST);
            cache_op[CB_INV_COND]   = (op_q == OP_INV_COND);
            cache_op[CB_FLUSH_OUT]  = (op_q == OP_FLUSH_OUT);
            cache_op[CB_FLUSH_COND] = (op_q == OP_FLUSH_COND);
        end
    end

endmodule

// File: rtl/cmdbuf_engine_chk.sv
module cmdbuf_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_req,
    input logic              launch_valid,
    input logic              launch_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              error,
    input logic              busy,
    input logic              consumed,
    input logic [4:0]        cache_op
);

    // R2: consumed holds until a new start
    a_r2_consumed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        consumed && !start |=> consumed);

    // R5: a cache pulse never lasts two cycles
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|cache_op) |=> (cache_op == 5'd0));

    // R6: launch request held until accepted
    a_r6_launch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid && !launch_ready |=> launch_valid);

    // R6: no fetch while a launch is pending
    a_r6_no_fetch_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> !rd_req);

    // R9: counter dump is a pair of writes to consecutive addresses
    a_r9_dump_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |=> wr_en);

    a_r9_dump_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));

    a_r9_dump_len: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |=> !wr_en);

    // R10: error is sticky and stops all reading
    a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    a_r10_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !rd_req && !busy);

endmodule

bind cmdbuf_engine cmdbuf_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .rd_req       (rd_req),
    .launch_valid (launch_valid),
    .launch_ready (launch_ready),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .error        (error),
    .busy         (busy),
    .consumed     (consumed),
    .cache_op     (cache_op)
);

// File: tb/test_cmdbuf_engine.sv
module test_cmdbuf_engine;

    localparam int CLK_PERIOD = 10;
    localparam int B_NIN  = 3;
    localparam int B_NOUT = 2;
    localparam int AW     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] buf_addr = '0;
    logic [15:0] buf_len = '0;
    logic busy, consumed, error;
    logic rd_req;
    logic [AW-1:0] rd_addr;
    logic rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic wr_en;
    logic [AW-1:0] wr_addr;
    logic [31:0] wr_data;
    logic [B_NIN-1:0][31:0]  in_addr;
    logic [B_NIN-1:0][3:0]   in_fmt;
    logic [B_NIN-1:0][2:0]   in_comp;
    logic [B_NOUT-1:0][31:0] out_addr;
    logic [B_NOUT-1:0][3:0]  out_fmt;
    logic [B_NOUT-1:0][2:0]  out_comp;
    logic [31:0] const_addr, prog_addr, cond_addr;
    logic [3:0]  cond_fmt;
    logic [2:0]  cond_test;
    logic [15:0] dom_x0, dom_y0, dom_x1, dom_y1;
    logic [4:0]  cache_op;
    logic launch_valid;
    logic launch_ready = 1'b0;
    logic array_busy = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] mem [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        rd_valid <= rd_req;
        rd_data  <= mem[rd_addr[7:0]];
        if (wr_en) mem[wr_addr[7:0]] <= wr_data;
    end

    cmdbuf_engine #(.ADDR_W(AW), .NUM_IN(B_NIN), .NUM_OUT(B_NOUT)) i_cmdbuf_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_addr(buf_addr), .buf_len(buf_len),
        .busy(busy), .consumed(consumed), .error(error),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .in_addr(in_addr), .in_fmt(in_fmt), .in_comp(in_comp),
        .out_addr(out_addr), .out_fmt(out_fmt), .out_comp(out_comp),
        .const_addr(const_addr), .prog_addr(prog_addr), .cond_addr(cond_addr),
        .cond_fmt(cond_fmt), .cond_test(cond_test),
        .dom_x0(dom_x0), .dom_y0(dom_y0), .dom_x1(dom_x1), .dom_y1(dom_y1),
        .cache_op(cache_op), .launch_valid(launch_valid), .launch_ready(launch_ready),
        .array_busy(array_busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        launch_ready = 1'b0;
        array_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_buf(input int base, input int len);
        buf_addr = AW'(base);
        buf_len  = 16'(len);
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_done();
        int g = 0;
        while (busy && g < 2000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic t_reset();
        check("R1 in_addr", in_addr[1], 0);
        check("R1 const_addr", const_addr, 0);
        check("R1 prog_addr", prog_addr, 0);
        check("R1 cond_test", 32'(cond_test), 0);
        check("R1 domain", {dom_x1, dom_y1}, 0);
        check("R1 flags", {26'd0, busy, consumed, error, launch_valid, rd_req, wr_en}, 0);
        check("R1 cache_op", 32'(cache_op), 0);
    endtask

    task automatic t_config();
        mem[0]  = 32'h01; mem[1]  = 1; mem[2]  = 32'h1000; mem[3]  = 2; mem[4] = 4;
        mem[5]  = 32'h02; mem[6]  = 1; mem[7]  = 32'h2000; mem[8]  = 1; mem[9] = 2;
        mem[10] = 32'h03; mem[11] = 32'h3000;
        mem[12] = 32'h04; mem[13] = 32'h4000; mem[14] = 3;
        mem[15] = 32'h05; mem[16] = 32'h5000;
        mem[17] = 32'h0B; mem[18] = 6;
        start_buf(0, 19);
        wait_done();
        check("R3 in_addr[1]", in_addr[1], 32'h1000);
        check("R3 in_fmt/comp[1]", {in_fmt[1], in_comp[1]}, {25'd0, 4'd2, 3'd4});
        check("R3 out_addr[1]", out_addr[1], 32'h2000);
        check("R3 out_fmt/comp[1]", {out_fmt[1], out_comp[1]}, {25'd0, 4'd1, 3'd2});
        check("R3 const_addr", const_addr, 32'h3000);
        check("R3 cond_addr", cond_addr, 32'h4000);
        check("R3 cond_fmt", 32'(cond_fmt), 3);
        check("R3 prog_addr", prog_addr, 32'h5000);
        check("R3 cond_test", 32'(cond_test), 6);
        check("R2 consumed", 32'(consumed), 1);
    endtask

    task automatic t_range();
        mem[32] = 32'h01; mem[33] = 3; mem[34] = 32'hDEAD; mem[35] = 1; mem[36] = 1;
        mem[37] = 32'h02; mem[38] = 2; mem[39] = 32'hBEEF; mem[40] = 1; mem[41] = 1;
        mem[42] = 32'h01; mem[43] = 2; mem[44] = 32'h7000; mem[45] = 5; mem[46] = 3;
        start_buf(32, 15);
        wait_done();
        check("R4 in_addr[0]", in_addr[0], 0);
        check("R4 in_addr[1]", in_addr[1], 32'h1000);
        check("R4 in_addr[2] last legal", in_addr[2], 32'h7000);
        check("R4 out_addr[0]", out_addr[0], 0);
        check("R4 out_addr[1]", out_addr[1], 32'h2000);
    endtask

    task automatic t_cache();
        logic [4:0] seen [0:7];
        int n = 0;
        int g = 0;
        mem[64] = 32'h06; mem[65] = 32'h07; mem[66] = 32'h08; mem[67] = 32'h09; mem[68] = 32'h0A;
        start_buf(64, 5);
        while (busy && g < 200) begin
            if (cache_op != 5'd0 && n < 8) begin
                seen[n] = cache_op;
                n++;
            end
            @(negedge clk);
            g++;
        end
        check("R5 pulse cycles", n, 5);
        for (int i = 0; i < 5; i++) begin
            if (i < n) check("R5 pulse bit", 32'(seen[i]), 32'(1) << i);
        end
    endtask

    task automatic t_launch();
        int g = 0;
        mem[80] = 32'h0C; mem[81] = 1; mem[82] = 2; mem[83] = 30; mem[84] = 40;
        mem[85] = 32'h0D; mem[86] = 32'h05; mem[87] = 32'h55;
        launch_ready = 1'b0;
        start_buf(80, 8);
        while (!launch_valid && g < 200) begin
            @(negedge clk);
            g++;
        end
        check("R6 domain", {dom_x0, dom_y0}, {16'd1, 16'd2});
        check("R6 domain far", {dom_x1, dom_y1}, {16'd30, 16'd40});
        repeat (5) @(negedge clk);
        check("R6 valid held", 32'(launch_valid), 1);
        check("R6 no fetch", 32'(rd_req), 0);
        check("R6 prog not yet", prog_addr, 32'h5000);
        launch_ready = 1'b1;
        @(negedge clk);
        launch_ready = 1'b0;
        check("R6 valid dropped", 32'(launch_valid), 0);
        wait_done();
        check("R6 continues", prog_addr, 32'h55);
    endtask

    task automatic t_barrier();
        mem[100] = 32'h0E; mem[101] = 32'h03; mem[102] = 32'h77;
        array_busy = 1'b1;
        start_buf(100, 3);
        repeat (12) @(negedge clk);
        check("R7 blocked", const_addr, 32'h3000);
        check("R7 still busy", 32'(busy), 1);
        array_busy = 1'b0;
        wait_done();
        check("R7 released", const_addr, 32'h77);
    endtask

    task automatic t_perf();
        mem[120] = 32'h0F; mem[121] = 32'h10; mem[122] = 200;
        mem[123] = 32'h0F; mem[124] = 32'h10; mem[125] = 210;
        array_busy = 1'b1;
        start_buf(120, 3);
        wait_done();
        array_busy = 1'b0;
        // R2 timing: two words after the clear cost 4 cycles before the dump executes
        check("R9 total busy", mem[200], 4);
        check("R8 active busy", mem[201], 4);
        start_buf(123, 3);
        wait_done();
        check("R2 total idle", mem[210], 4);
        check("R8 active idle", mem[211], 0);
    endtask

    task automatic t_zero();
        start_buf(10, 0);
        check("R2 zero consumed", 32'(consumed), 1);
        check("R2 zero no busy", 32'(busy), 0);
        repeat (3) @(negedge clk);
        check("R2 zero no effect", const_addr, 32'h77);
    endtask

    task automatic t_trunc();
        do_reset();
        mem[130] = 32'h03;
        start_buf(130, 1);
        wait_done();
        check("R11 error", 32'(error), 1);
        check("R11 not applied", const_addr, 0);
        check("R11 consumed", 32'(consumed), 1);
    endtask

    task automatic t_unknown();
        do_reset();
        mem[140] = 32'h99; mem[141] = 32'h03; mem[142] = 32'hAB;
        start_buf(140, 3);
        wait_done();
        repeat (4) @(negedge clk);
        check("R10 error", 32'(error), 1);
        check("R10 halted", const_addr, 0);
        check("R10 not consumed", 32'(consumed), 0);
        start_buf(10, 2);
        repeat (8) @(negedge clk);
        check("R10 start ignored", const_addr, 0);
        check("R10 sticky", {busy, error}, 32'b01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
        do_reset();
        t_reset();
        t_config();
        t_range();
        t_cache();
        t_launch();
        t_barrier();
        t_perf();
        t_zero();
        t_trunc();
        t_unknown();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule